// File: doc/BRIEF.md
# Shared Timer Clock Prescaler Selector

This block makes the count-enable pulses for a group of timer channels. All channels share one free-running prescaler counter. Each channel has its own 3-bit source select, and that select chooses where the channel's enable comes from: the full system clock, one of four divided taps, or a detected edge on the channel's own external pin. Every enable is a registered pulse, one system clock wide, in the system clock domain. The timer counter that sits next to this block simply increments on each cycle in which its enable is high.

The prescaler does not watch any channel's select, so when a channel starts counting from a tap, the phase of its first pulse is set by where the shared counter happens to be. A clear strobe zeroes the shared counter. This lets software line the taps up with program flow, and it moves the phase of every channel at the same moment. The external pin is captured on the falling clock edge and then passes through two rising-edge flops before the edge detector. A pin change therefore reaches the counter two and a half to three and a half cycles later.

Top module: `tmr_clk_sel`

## Requirements
- R1: Select code 0 stops the channel: its enable stays low.
- R2: Select code 1 holds the channel's enable high on every cycle.
- R3: Select codes 2, 3, 4 and 5 give one-cycle enable pulses spaced exactly 8, 64, 256 and 1024 cycles apart, in that order.
- R4: After a channel switches from code 0 to a tap code with divisor N, its first enable comes between 1 and N+1 rising edges later.
- R5: The shared prescaler runs freely. Channels on the same tap pulse in the same cycle, whenever each of them was selected, and changing another channel's select leaves their spacing unchanged.
- R6: A clear strobe sampled at a rising edge zeroes the prescaler. The first pulse of the tap with divisor N then appears on every channel using that tap exactly N rising edges after that edge.
- R7: Code 7 gives exactly one enable pulse for each rising edge on the channel's pin. Falling edges give no pulse.
- R8: Code 6 gives exactly one enable pulse for each falling edge on the channel's pin. Rising edges give no pulse.
- R9: If the pin changes while the clock is high, the enable is high in the cycle that starts at the 2nd rising edge after the change. If the pin changes while the clock is low, the enable is high in the cycle that starts at the 3rd rising edge after the change.
- R10: No edge pulse is produced for pin history from before reset, or from before the cycle in which a channel's select changes. Such a pulse is held back for three cycles after the change.
- R11: While reset is asserted, all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psc_clr_i | input | 1 | Clear strobe for the shared prescaler |
| sel_i | input | 3*NCH | Source select per channel; channel c is bits [3c+2:3c] |
| ext_pin_i | input | NCH | External count pin per channel |
| cnt_en_o | output | NCH | One-cycle count enable per channel |

## Verification
The hardest case to reach is the half-cycle capture stage. It only shows up when the pin changes at a chosen point inside a clock period. The stimulus drives pin edges at fixed offsets into the high half and into the low half of the period, then counts rising edges until the enable appears, which separates the two-edge and three-edge latencies. A second hard case is a pin edge that arrives while the channel is stopped, with an edge select applied right after it. The bench builds this by switching the select one cycle after a pin rise and checks that no stale pulse comes out.

// File: rtl/tmr_clk_pkg.sv
`timescale 1ns/1ps
package tmr_clk_pkg;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;
  localparam int PSC_W    = 10;
  // log2 of each tap divisor, indexed by select code minus 2
  localparam int TAP_SHIFT [NUM_TAPS] = '{3, 6, 8, 10};

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF   = 3'd0,
    SRC_SYS   = 3'd1,
    SRC_D8    = 3'd2,
    SRC_D64   = 3'd3,
    SRC_D256  = 3'd4,
    SRC_D1024 = 3'd5,
    SRC_FALL  = 3'd6,
    SRC_RISE  = 3'd7
  } src_sel_e;
endpackage

// File: rtl/tmr_psc_core.sv
`timescale 1ns/1ps
module tmr_psc_core
  import tmr_clk_pkg::*;
#(
  parameter int W = PSC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam logic [W-1:0] MASK = W'((1 << TAP_SHIFT[k]) - 1);
    assign tap_o[k] = (cnt_q & MASK) == MASK;
  end

  AST_TAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[0] |=> !tap_o[0]); // R3
  AST_CLR_NO_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tap_o == '0)); // R6
endmodule

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic hold_i,
  output logic rise_o,
  output logic fall_o
);
  logic half_q, s1_q, s2_q;
  logic [1:0] prime_q;
  logic ok;

  // half-cycle capture: value present at end of high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= pin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prime_q <= '0;
    end else begin
      s1_q <= half_q;
      s2_q <= s1_q;
      if (hold_i)              prime_q <= '0;
      else if (prime_q != 2'd3) prime_q <= prime_q + 2'd1;
    end
  end

  assign ok     = (prime_q == 2'd3) && !hold_i;
  assign rise_o = ok &&  s1_q && !s2_q;
  assign fall_o = ok && !s1_q &&  s2_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R8
endmodule

// File: rtl/tmr_chan_src.sv
`timescale 1ns/1ps
module tmr_chan_src
  import tmr_clk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                pin_i,
  output logic                en_o
);
  src_sel_e   sel;
  logic [SEL_W-1:0] sel_q;
  logic sel_chg, rise, fall, src, en_q;

  assign sel     = src_sel_e'(sel_i);
  assign sel_chg = sel_i != sel_q;

  tmr_pin_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .hold_i (sel_chg),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    unique case (sel)
      SRC_OFF:   src = 1'b0;
      SRC_SYS:   src = 1'b1;
      SRC_D8:    src = tap_i[0];
      SRC_D64:   src = tap_i[1];
      SRC_D256:  src = tap_i[2];
      SRC_D1024: src = tap_i[3];
      SRC_FALL:  src = fall;
      SRC_RISE:  src = rise;
      default:   src = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      sel_q <= sel_i;
      en_q  <= src;
    end
  end

  assign en_o = en_q;

  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_OFF) |=> !en_o); // R1
  AST_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_SYS) |=> en_o); // R2
  AST_SELCHG_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_chg && sel_i >= SRC_FALL) |=> !en_o); // R10
endmodule

// File: rtl/tmr_clk_sel.sv
`timescale 1ns/1ps
module tmr_clk_sel
  import tmr_clk_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 psc_clr_i,
  input  logic [NCH*SEL_W-1:0] sel_i,
  input  logic [NCH-1:0]       ext_pin_i,
  output logic [NCH-1:0]       cnt_en_o
);
  logic [NUM_TAPS-1:0] tap;

  tmr_psc_core #(.W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psc_clr_i),
    .tap_o  (tap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_chan_src u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel_i[c*SEL_W +: SEL_W]),
      .tap_i  (tap),
      .pin_i  (ext_pin_i[c]),
      .en_o   (cnt_en_o[c])
    );
  end

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cnt_en_o == '0)); // R11
endmodule

// File: tb/tmr_clk_sel_tb_top.sv
`timescale 1ns/1ps
module tmr_clk_sel_tb_top;
  localparam int NCH = 3;
  localparam int NV  = 6;
  localparam int WIN = 2048;
  localparam logic [2:0] VEC_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  localparam int         VEC_CNT [NV] = '{0, 2048, 256, 32, 8, 2};
  localparam int         VEC_GAP [NV] = '{0, 1, 8, 64, 256, 1024};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psc_clr = 1'b0;
  logic [2:0] sel [NCH];
  logic [NCH*3-1:0] sel_flat;
  logic [NCH-1:0] pin = '0;
  logic [NCH-1:0] en;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  assign sel_flat = {sel[2], sel[1], sel[0]};

  tmr_clk_sel #(.NCH(NCH)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .psc_clr_i (psc_clr),
    .sel_i     (sel_flat),
    .ext_pin_i (pin),
    .cnt_en_o  (en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // rising edges until enable of channel ch is seen (sampled 1 ns after edge), -1 if none
  task automatic wait_en(input int ch, input int maxk, output int k);
    k = -1;
    for (int i = 1; i <= maxk; i++) begin
      @(posedge clk); #1;
      if (en[ch]) begin k = i; break; end
    end
  endtask

  task automatic quiet(input int ch, input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (en[ch]) hits++;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    int k, hits, cnt, last, gap_bad;
    sel[0] = 3'd0; sel[1] = 3'd0; sel[2] = 3'd7;
    pin = 3'b100;
    // R11 and R10: reset with pin high on a rising-edge channel
    repeat (3) @(negedge clk);
    chk("R11 reset enables", int'(en), 0);
    rst_n = 1'b1;
    quiet(2, 8, hits);
    chk("R10 no pulse after reset", hits, 0);

    // table: per select code, pulse count and spacing on channel 0
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); sel[0] = VEC_SEL[v];
      repeat (3) @(negedge clk);
      cnt = 0; last = -1; gap_bad = 0;
      for (int t = 0; t < WIN; t++) begin
        @(negedge clk);
        if (en[0]) begin
          if (last >= 0 && t - last != VEC_GAP[v]) gap_bad++;
          last = t; cnt++;
        end
      end
      chk(v == 0 ? "R1 stop count" : (v == 1 ? "R2 full rate count" : "R3 tap count"),
          cnt, VEC_CNT[v]);
      chk("R3 tap spacing", gap_bad, 0);
    end

    // R4: first count latency from select, several offsets
    for (int o = 0; o < 3; o++) begin
      for (int tp = 0; tp < 2; tp++) begin
        @(negedge clk); sel[1] = 3'd0;
        repeat (o * 211 + 1) @(negedge clk);
        sel[1] = (tp == 0) ? 3'd2 : 3'd5;
        wait_en(1, 1100, k);
        chk("R4 first count in range", int'(k >= 1 && k <= ((tp == 0) ? 9 : 1025)), 1);
      end
    end

    // R5: shared phase, other channel select changes
    @(negedge clk); sel[0] = 3'd3; sel[1] = 3'd0;
    repeat (37) @(negedge clk); sel[2] = 3'd3;
    cnt = 0; last = -1; gap_bad = 0; hits = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (t % 7 == 0) sel[1] = 3'(t % 6);
      if (en[0] != en[2]) hits++;
      if (en[0]) begin
        if (last >= 0 && t - last != 64) gap_bad++;
        last = t; cnt++;
      end
    end
    chk("R5 channels coincide", hits, 0);
    chk("R5 spacing kept", gap_bad, 0);
    chk("R5 pulse count", int'(cnt >= 6), 1);

    // R6: clear strobe realigns all channels
    @(negedge clk); sel[1] = 3'd2;
    repeat (5) @(negedge clk);
    psc_clr = 1'b1;
    @(posedge clk); #1 psc_clr = 1'b0;
    wait_en(1, 100, k);
    chk("R6 tap8 after clear", k, 8);
    wait_en(0, 100, k);
    chk("R6 tap64 after clear ch0", k, 64 - 8);
    chk("R6 tap64 after clear ch2", int'(en[2]), 1);

    // R7/R9: rising edges on channel 2
    @(negedge clk); sel[0] = 3'd0; sel[1] = 3'd0; sel[2] = 3'd7; pin = '0;
    repeat (6) @(negedge clk);
    @(posedge clk); #0.5 pin[2] = 1'b1;
    wait_en(2, 10, k);
    chk("R9 rise in high half latency", k, 2);
    quiet(2, 6, hits);
    chk("R7 single pulse per rise", hits, 0);
    @(posedge clk); #3.5 pin[2] = 1'b0;
    quiet(2, 8, hits);
    chk("R7 falling edge ignored", hits, 0);

    // R8/R9: falling edges on channel 2
    @(negedge clk); sel[2] = 3'd6;
    repeat (6) @(negedge clk);
    @(posedge clk); #1 pin[2] = 1'b1;
    quiet(2, 8, hits);
    chk("R8 rising edge ignored", hits, 0);
    @(posedge clk); #3.5 pin[2] = 1'b0;
    wait_en(2, 10, k);
    chk("R9 fall in low half latency", k, 3);
    quiet(2, 6, hits);
    chk("R8 single pulse per fall", hits, 0);

    // R10: edge while stopped, edge select applied just after
    @(negedge clk); sel[1] = 3'd0; pin[1] = 1'b0;
    repeat (6) @(negedge clk);
    @(posedge clk); #1 pin[1] = 1'b1;
    @(posedge clk); @(posedge clk); #1 sel[1] = 3'd7;
    quiet(1, 8, hits);
    chk("R10 no stale pulse on select change", hits, 0);

    done();
  end
endmodule